// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register file of an ATA-style storage target. A host reaches it over a simple byte bus with a 4-bit offset, single-cycle read and write strobes and an 8-bit data path. It stores the sector, cylinder-low, cylinder-high and drive/head bytes. It presents them to the device back end in two forms. One is a 28-bit logical block address. The other is a cylinder/head/sector breakout. A mode bit in the drive/head byte selects which of the two is meant.

The block also serves the status byte at two offsets. Both offsets return the same value. A read at the primary offset clears the pending interrupt, and a read at the alternate offset leaves it pending. The device back end supplies busy, ready, an interrupt pulse and six low status flags. A write to the status offset is taken as a command and is passed on as a one-cycle pulse. The device answers the host only while the drive-select bit matches its configured drive number.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, the sector, cylinder-low and cylinder-high registers hold 0. The stored drive/head fields are all 0, so offset 6h reads 8'hA0. intrq, cmd_valid and the ready bit are all 0.
- R2: The drive/head byte at offset 6h reads back with bits 7 and 5 forced to 1. Bit 6 (the mode bit), bit 4 (the drive-select bit) and bits 3..0 read back as last written.
- R3: When drive/head bit 6 is 1, lba_mode is 1 and lba is {dh[3:0], cyl_high, cyl_low, sector}. When bit 6 is 0, lba_mode is 0 and lba is 0.
- R4: chs_head is drive/head bits 3..0, chs_cyl is {cyl_high, cyl_low} and chs_sector is the sector register, in either mode.
- R5: Offsets 3h, 4h and 5h read and write sector, cylinder-low and cylinder-high. Any offset other than 3h to 7h and Eh reads 0.
- R6: When dev_busy is 0, the status byte is {0, ready, dev_flags[5:0]}. The ready bit is dev_ready registered once, so it is 0 from reset until one cycle after dev_ready rises. When dev_busy is 1, the status byte reads 8'h80.
- R7: Offsets 7h and Eh return the same status byte.
- R8: A read at 7h by the selected device clears intrq on the next edge. A read at Eh leaves intrq unchanged. If a clearing read and dev_irq fall on the same edge, the clear wins.
- R9: A dev_irq pulse sets intrq on the next edge, and intrq then stays 1 until it is cleared.
- R10: A write at 7h by the selected device with dev_busy low produces cmd_valid for exactly one cycle after the write edge, with cmd_byte equal to the written data.
- R11: While dev_busy is 1, host writes change no register and raise no command.
- R12: When drive/head bit 4 differs from cfg_drive, every read returns 0, a read at 7h does not clear intrq, and a write at 7h raises no command. Writes to offsets 3h to 6h are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_drive | input | 1 | This device's drive number (0 master, 1 slave) |
| host_addr | input | 4 | Task-file offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from offset |
| dev_busy | input | 1 | Device busy |
| dev_ready | input | 1 | Device ready to accept a command |
| dev_irq | input | 1 | One-cycle interrupt request pulse |
| dev_flags | input | 6 | Status bits 5..0 |
| intrq | output | 1 | Pending interrupt to host |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte written at 7h |
| lba_mode | output | 1 | Drive/head bit 6 |
| lba | output | 28 | Assembled logical block address |
| chs_head | output | 4 | Head number |
| chs_cyl | output | 16 | Cylinder number |
| chs_sector | output | 8 | Sector number |

## Verification
The interrupt set and the interrupt clear can fall on the same edge. To provoke this, the bench pulses dev_irq in the same cycle as a host read at 7h, and again with a read at Eh. The result is judged against a behavioural model that applies the clear after the set. A second collision is a host write that arrives while dev_busy is high. A random phase overlaps strobes, busy and drive-select changes freely, and every output is compared with the model on every clock.

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_drive,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          dev_busy,
  input  logic          dev_ready,
  input  logic          dev_irq,
  input  logic [5:0]    dev_flags,
  output logic          intrq,
  output logic          cmd_valid,
  output logic [7:0]    cmd_byte,
  output logic          lba_mode,
  output logic [27:0]   lba,
  output logic [3:0]    chs_head,
  output logic [15:0]   chs_cyl,
  output logic [7:0]    chs_sector
);
  localparam logic [AW-1:0] OFS_SEC  = AW'(3);
  localparam logic [AW-1:0] OFS_CYLL = AW'(4);
  localparam logic [AW-1:0] OFS_CYLH = AW'(5);
  localparam logic [AW-1:0] OFS_DH   = AW'(6);
  localparam logic [AW-1:0] OFS_STAT = AW'(7);
  localparam logic [AW-1:0] OFS_ALT  = AW'(14);

  logic [7:0] sec_q, cyll_q, cylh_q;
  logic       mode_q, drv_q, rdy_q;
  logic [3:0] hs_q;
  logic       selected, wr_ok, stat_clear;
  logic [7:0] status_byte, dh_byte;

  assign selected    = (drv_q == cfg_drive);
  assign wr_ok       = host_wr && !dev_busy;
  assign stat_clear  = host_rd && selected && (host_addr == OFS_STAT);
  assign status_byte = dev_busy ? 8'h80 : {1'b0, rdy_q, dev_flags};
  assign dh_byte     = {1'b1, mode_q, 1'b1, drv_q, hs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      cyll_q <= '0;
      cylh_q <= '0;
      mode_q <= 1'b0;
      drv_q  <= 1'b0;
      hs_q   <= '0;
    end else if (wr_ok) begin
      case (host_addr)
        OFS_SEC:  sec_q  <= host_wdata;
        OFS_CYLL: cyll_q <= host_wdata;
        OFS_CYLH: cylh_q <= host_wdata;
        OFS_DH: begin
          mode_q <= host_wdata[6];
          drv_q  <= host_wdata[4];
          hs_q   <= host_wdata[3:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      intrq     <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      rdy_q     <= dev_ready;
      if (stat_clear)   intrq <= 1'b0;
      else if (dev_irq) intrq <= 1'b1;
      cmd_valid <= wr_ok && selected && (host_addr == OFS_STAT);
      if (wr_ok && selected && host_addr == OFS_STAT) cmd_byte <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (selected) begin
      case (host_addr)
        OFS_SEC:          host_rdata = sec_q;
        OFS_CYLL:         host_rdata = cyll_q;
        OFS_CYLH:         host_rdata = cylh_q;
        OFS_DH:           host_rdata = dh_byte;
        OFS_STAT, OFS_ALT: host_rdata = status_byte;
        default:          host_rdata = '0;
      endcase
    end
  end

  assign lba_mode   = mode_q;
  assign lba        = mode_q ? {hs_q, cylh_q, cyll_q, sec_q} : '0;
  assign chs_head   = hs_q;
  assign chs_cyl    = {cylh_q, cyll_q};
  assign chs_sector = sec_q;

  a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFS_STAT && drv_q == cfg_drive) |=> !intrq);
  a_r8_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (intrq && host_rd && host_addr == OFS_ALT) |=> intrq);
  a_r9_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && !(host_rd && host_addr == OFS_STAT && drv_q == cfg_drive)) |=> intrq);
  a_r10_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(host_wr && host_addr == OFS_STAT && !dev_busy));
  a_r11_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_busy && host_wr) |=> ($stable(sec_q) && $stable(cyll_q) && $stable(cylh_q) && !cmd_valid));
  a_r2_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_DH && drv_q == cfg_drive) |-> (host_rdata[7] && host_rdata[5]));

  always_comb begin
    if (rst_n && dev_busy && selected && (host_addr == OFS_STAT || host_addr == OFS_ALT))
      a_r6_busy_mask: assert (host_rdata == 8'h80);
  end
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic       cfg_drive = 0;
  logic [3:0] host_addr = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic       dev_busy = 0, dev_ready = 0, dev_irq = 0;
  logic [5:0] dev_flags = 0;
  logic       intrq, cmd_valid, lba_mode;
  logic [7:0] cmd_byte, chs_sector;
  logic [27:0] lba;
  logic [3:0] chs_head;
  logic [15:0] chs_cyl;

  ata_taskfile_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_drive(cfg_drive), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_busy(dev_busy), .dev_ready(dev_ready), .dev_irq(dev_irq), .dev_flags(dev_flags),
    .intrq(intrq), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .lba_mode(lba_mode),
    .lba(lba), .chs_head(chs_head), .chs_cyl(chs_cyl), .chs_sector(chs_sector));

  int total = 0, bad = 0;
  // reference state
  int m_sec, m_cl, m_ch, m_hs, m_mode, m_drv, m_rdy, m_irq, m_cv, m_cb;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_rdata();
    int st;
    if (m_drv != cfg_drive) return 0;
    st = dev_busy ? 'h80 : ((m_rdy << 6) | dev_flags);
    case (host_addr)
      3: return m_sec;
      4: return m_cl;
      5: return m_ch;
      6: return 'hA0 | (m_mode << 6) | (m_drv << 4) | m_hs;
      7, 14: return st;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    chk((host_addr == 7 || host_addr == 14) ? "R6 R7 R12" : "R2 R5 R12", host_rdata, model_rdata());
    chk("R3", lba_mode, m_mode);
    chk("R3", lba, m_mode ? ((m_hs << 24) | (m_ch << 16) | (m_cl << 8) | m_sec) : 0);
    chk("R4", {chs_head, chs_cyl, chs_sector}, (m_hs << 24) | (m_ch << 16) | (m_cl << 8) | m_sec);
    chk("R8 R9", intrq, m_irq);
    chk("R10 R11", cmd_valid, m_cv);
    if (m_cv) chk("R10", cmd_byte, m_cb);
  endtask

  task automatic model_clock();
    bit sel = (m_drv == cfg_drive);
    bit wok = host_wr && !dev_busy;
    m_cv = (wok && sel && host_addr == 7);
    if (m_cv) m_cb = host_wdata;
    if (wok) case (host_addr)
      3: m_sec = host_wdata;
      4: m_cl = host_wdata;
      5: m_ch = host_wdata;
      6: begin m_mode = host_wdata[6]; m_drv = host_wdata[4]; m_hs = host_wdata[3:0]; end
      default: ;
    endcase
    if (host_rd && sel && host_addr == 7) m_irq = 0;
    else if (dev_irq) m_irq = 1;
    m_rdy = dev_ready;
  endtask

  // one cycle: inputs set at negedge, compared, model advanced at posedge
  task automatic step(input int a, input bit w, input bit r, input int d,
                      input bit bsy, input bit rdy, input bit irq, input int fl);
    host_addr = a[3:0]; host_wr = w; host_rd = r; host_wdata = d[7:0];
    dev_busy = bsy; dev_ready = rdy; dev_irq = irq; dev_flags = fl[5:0];
    #1 compare_all();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic idle(input int a);
    step(a, 0, 0, 0, 0, dev_ready, 0, dev_flags);
  endtask

  initial begin
    m_sec = 0; m_cl = 0; m_ch = 0; m_hs = 0; m_mode = 0; m_drv = 0;
    m_rdy = 0; m_irq = 0; m_cv = 0; m_cb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    host_addr = 6; #1 chk("R1", host_rdata, 'hA0);
    chk("R1", {intrq, cmd_valid}, 0);
    host_addr = 7; #1 chk("R1 ready low", host_rdata, 0);
    // R2 R3 R5: LBA mode assembly
    step(3, 1, 0, 'h12, 0, 0, 0, 0);
    step(4, 1, 0, 'h34, 0, 0, 0, 0);
    step(5, 1, 0, 'h56, 0, 0, 0, 0);
    step(6, 1, 0, 'h4B, 0, 0, 0, 0);
    idle(6);
    chk("R2 fixed ones", host_rdata, 'hEB);
    chk("R3 lba", lba, 'hB563412);
    // R4 CHS mode
    step(6, 1, 0, 'h05, 0, 0, 0, 0);
    idle(3);
    chk("R4 head", chs_head, 5);
    chk("R3 lba zero in chs", lba, 0);
    step(9, 0, 1, 0, 0, 0, 0, 0);
    // R6 R7 ready delay and flags
    step(7, 0, 0, 0, 0, 1, 0, 'h15);
    chk("R6 ready after one edge", host_rdata, 'h55);
    step(14, 0, 1, 0, 1, 1, 0, 'h3F);
    // R9 set, R8 alt keeps, status clears
    step(0, 0, 0, 0, 0, 1, 1, 0);
    step(14, 0, 1, 0, 0, 1, 0, 0);
    chk("R8 alt keeps", intrq, 1);
    step(7, 0, 1, 0, 0, 1, 1, 0);   // clear and set collide
    chk("R8 clear wins", intrq, 0);
    step(14, 0, 1, 0, 0, 1, 1, 0);  // set with alt read
    chk("R9 set", intrq, 1);
    // R10 command
    step(7, 1, 0, 'hEC, 0, 1, 0, 0);
    chk("R10 pulse", cmd_valid, 1);
    idle(7);
    chk("R10 one cycle", cmd_valid, 0);
    // R11 busy ignores writes
    step(3, 1, 0, 'hFF, 1, 1, 0, 0);
    step(7, 1, 0, 'hA1, 1, 1, 0, 0);
    idle(3);
    chk("R11 sector kept", host_rdata, 'h12);
    // R12 deselect by writing drv=1
    step(6, 1, 0, 'h10, 0, 1, 0, 0);
    step(7, 0, 1, 0, 0, 1, 0, 0);
    chk("R12 status read ignored", intrq, 1);
    step(7, 1, 0, 'h20, 0, 1, 0, 0);
    chk("R12 no command", cmd_valid, 0);
    step(4, 1, 0, 'h77, 0, 1, 0, 0);
    cfg_drive = 1;
    idle(4);
    chk("R12 write stored", host_rdata, 'h77);
    cfg_drive = 0;
    // random phase
    for (int i = 0; i < 2000; i++) begin
      int a = $urandom_range(0, 15);
      bit w = ($urandom_range(0, 3) == 0);
      bit r = !w && ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 63) == 0) cfg_drive = ~cfg_drive;
      step(a, w, r, $urandom_range(0, 255), $urandom_range(0, 4) == 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 63));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule